// File: doc/BRIEF.md
# Weekday Alarm and One-Second Interrupt Unit

This unit sits next to a BCD clock core and turns its running time into two interrupt lines. The alarm line fires when the current hour and minute equal two programmed BCD values and the current weekday is among those selected in a one-hot day mask. The match is taken only on the tick that starts second 00, so the alarm resolution is one minute. The second line pulses an event on every one-second tick. Software that needs second-level precision arms it and counts ticks after the minute alarm has fired.

Each source has an enable bit in a control register and a sticky pending bit in a status register that is cleared by writing one to it. The clock core drives `sec_tick` for one cycle in the cycle where `cur_sec`, `cur_min`, `cur_hour` and `cur_wday` already show the second that has just begun. Software reaches the registers through a small single-cycle write and registered-read bus.

Top module: `wkalm_top`

## Requirements
- R1: After a synchronous reset every register reads zero and both interrupt lines are low.
- R2: The control register at address 0 holds the alarm enable in bit 4 and the one-second enable in bit 3. All other bits read as zero. Read data appears on `bus_rdata` one clock after the address is presented.
- R3: Address 2 holds an 8-bit BCD alarm minute, address 3 an 8-bit BCD alarm hour, and address 4 a 7-bit weekday mask in which bit n selects weekday n. Bit 7 of the mask reads as zero.
- R4: On a tick with `cur_sec` equal to 00, `cur_min` equal to the alarm minute, `cur_hour` equal to the alarm hour and the mask bit at `cur_wday` set, the alarm pending bit (status bit 0) becomes one, provided the alarm enable is set.
- R5: A tick whose second is not 00 never sets the alarm pending bit, even when minute, hour and day match. An alarm therefore fires at most once per minute.
- R6: A tick on a weekday whose mask bit is clear never sets the alarm pending bit.
- R7: While the one-second enable is set, every tick sets the one-second pending bit (status bit 1).
- R8: Each interrupt output equals its pending bit AND its enable bit, delayed by one register. Clearing the enable lowers the output and keeps the pending bit. Setting the enable again raises the output once more.
- R9: Writing the status register at address 1 clears each pending bit written with a one and leaves the bits written with a zero. An event that arrives in the same cycle as a clear wins, and its bit stays set.
- R10: Rewriting the control register (read-modify-write) does not change any pending bit.
- R11: An event that arrives while its source is disabled leaves no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse at the start of each second |
| cur_sec | input | 8 | Current second, BCD |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD (24-hour) |
| cur_wday | input | WD_W | Current weekday index 0..NDAYS-1 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq_alarm | output | 1 | Alarm interrupt level |
| irq_sec | output | 1 | One-second interrupt level |

## Verification
The bench builds the unit with its defaults: an 8-bit data path and a 7-day mask. With these values every one of the 128 mask values can be swept against every weekday. It also sweeps all 60 BCD minutes, all 24 BCD hours and the 59 non-zero seconds against a fixed alarm time. The small register set makes it possible to hit each enable/pending combination directly, including a status clear that lands in the same cycle as a tick.

// File: rtl/wkalm_pkg.sv
package wkalm_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_AMIN  = 3'd2,
    A_AHOUR = 3'd3,
    A_WMASK = 3'd4
  } reg_addr_e;

  localparam int unsigned BIT_ALM_EN = 4;
  localparam int unsigned BIT_SEC_EN = 3;

  localparam int unsigned SRC_ALM = 0;
  localparam int unsigned SRC_SEC = 1;
  localparam int unsigned NSRC    = 2;
endpackage

// File: rtl/wkalm_regs.sv
module wkalm_regs
  import wkalm_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned NDAYS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NSRC-1:0]   pend,
  output logic [DW-1:0]     rdata,
  output logic [NSRC-1:0]   en,
  output logic [NSRC-1:0]   clr,
  output logic [7:0]        alm_min,
  output logic [7:0]        alm_hour,
  output logic [NDAYS-1:0]  wmask
);
  logic en_alm_q, en_sec_q;
  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_alm_q <= 1'b0;
      en_sec_q <= 1'b0;
      alm_min  <= '0;
      alm_hour <= '0;
      wmask    <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL: begin
          en_alm_q <= wdata[BIT_ALM_EN];
          en_sec_q <= wdata[BIT_SEC_EN];
        end
        A_AMIN:  alm_min  <= wdata[7:0];
        A_AHOUR: alm_hour <= wdata[7:0];
        A_WMASK: wmask    <= wdata[NDAYS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    en          = '0;
    en[SRC_ALM] = en_alm_q;
    en[SRC_SEC] = en_sec_q;
    clr         = (we && addr == A_STAT) ? wdata[NSRC-1:0] : '0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL: begin
        rd_mux[BIT_ALM_EN] = en_alm_q;
        rd_mux[BIT_SEC_EN] = en_sec_q;
      end
      A_STAT:  rd_mux[NSRC-1:0]  = pend;
      A_AMIN:  rd_mux[7:0]       = alm_min;
      A_AHOUR: rd_mux[7:0]       = alm_hour;
      A_WMASK: rd_mux[NDAYS-1:0] = wmask;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/wkalm_match.sv
module wkalm_match #(
  parameter int unsigned NDAYS = 7,
  parameter int unsigned WD_W  = $clog2(NDAYS)
) (
  input  logic             tick,
  input  logic [7:0]       cur_sec,
  input  logic [7:0]       cur_min,
  input  logic [7:0]       cur_hour,
  input  logic [WD_W-1:0]  cur_wday,
  input  logic [7:0]       alm_min,
  input  logic [7:0]       alm_hour,
  input  logic [NDAYS-1:0] wmask,
  output logic             hit
);
  logic [NDAYS-1:0] day_sel;

  for (genvar d = 0; d < NDAYS; d++) begin : g_day
    assign day_sel[d] = wmask[d] && (cur_wday == WD_W'(d));
  end

  assign hit = tick && (cur_sec == 8'h00) && (cur_min == alm_min) &&
               (cur_hour == alm_hour) && (|day_sel);
endmodule

// File: rtl/wkalm_pend.sv
module wkalm_pend (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic en,
  input  logic clr,
  output logic pend_q,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (set_ev && en) || (pend_q && !clr);
      irq_q  <= pend_q && en;
    end
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_ev && en) |=> pend_q);
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && en) |=> irq_q);
  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_q);
  // R11
  gated_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(en));
endmodule

// File: rtl/wkalm_top.sv
module wkalm_top
  import wkalm_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned NDAYS = 7,
  parameter int unsigned WD_W  = $clog2(NDAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [WD_W-1:0]   cur_wday,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_alarm,
  output logic              irq_sec
);
  logic [NSRC-1:0]  en, clr, pend, irq, ev;
  logic [7:0]       alm_min, alm_hour;
  logic [NDAYS-1:0] wmask;
  logic             hit;

  wkalm_regs #(.DW(DW), .NDAYS(NDAYS)) i_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pend(pend), .rdata(bus_rdata), .en(en), .clr(clr),
    .alm_min(alm_min), .alm_hour(alm_hour), .wmask(wmask)
  );

  wkalm_match #(.NDAYS(NDAYS), .WD_W(WD_W)) i_match (
    .tick(sec_tick), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_wday(cur_wday), .alm_min(alm_min),
    .alm_hour(alm_hour), .wmask(wmask), .hit(hit)
  );

  always_comb begin
    ev          = '0;
    ev[SRC_ALM] = hit;
    ev[SRC_SEC] = sec_tick;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    wkalm_pend i_pend (
      .clk(clk), .rst(rst), .set_ev(ev[s]), .en(en[s]), .clr(clr[s]),
      .pend_q(pend[s]), .irq_q(irq[s])
    );
  end

  assign irq_alarm = irq[SRC_ALM];
  assign irq_sec   = irq[SRC_SEC];

  // R5
  alarm_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[SRC_ALM]) |-> $past(sec_tick && cur_sec == 8'h00));
  // R7
  sec_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && en[SRC_SEC]) |=> pend[SRC_SEC]);
endmodule

// File: tb/test_wkalm_top.sv
module test_wkalm_top;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int NDAYS = 7;
  localparam int WD_W = 3;

  logic clk = 0, rst = 1, sec_tick = 0, bus_we = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0;
  logic [WD_W-1:0] cur_wday = 0;
  logic [2:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, bus_rdata;
  logic irq_alarm, irq_sec;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  wkalm_top #(.DW(DW), .NDAYS(NDAYS), .WD_W(WD_W)) i_wkalm_top (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_alarm(irq_alarm), .irq_sec(irq_sec)
  );

  function automatic logic [7:0] bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic tick(input logic [7:0] s, input logic [7:0] m,
                      input logic [7:0] h, input int d);
    @(negedge clk);
    cur_sec = s; cur_min = m; cur_hour = h; cur_wday = WD_W'(d);
    sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq_alarm", irq_alarm, 0);
    chk("R1 irq_sec", irq_sec, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 reg", v, 0);
    end
    // R2 control layout
    wr(0, 8'hFF); rd(0, v); chk("R2 ctrl", v, 8'h18);
    wr(0, 8'h00); rd(0, v); chk("R2 ctrl clear", v, 0);
    // R3 alarm registers
    wr(2, 8'h45); wr(3, 8'h23); wr(4, 8'hFF);
    rd(2, v); chk("R3 min", v, 8'h45);
    rd(3, v); chk("R3 hour", v, 8'h23);
    rd(4, v); chk("R3 mask", v, 8'h7F);
    // R11 disabled sources record nothing
    tick(8'h00, 8'h45, 8'h23, 2); step();
    rd(1, v); chk("R11 status", v, 0);
    chk("R11 irq_alarm", irq_alarm, 0);
    chk("R11 irq_sec", irq_sec, 0);
    // R7 / R8 one-second source
    wr(0, 8'h08);
    tick(8'h17, 8'h10, 8'h05, 1); step();
    chk("R7 irq_sec", irq_sec, 1);
    rd(1, v); chk("R7 status", v, 8'h02);
    wr(0, 8'h00); step();
    chk("R8 irq drop", irq_sec, 0);
    rd(1, v); chk("R8 pend kept", v, 8'h02);
    wr(0, 8'h08); step();
    chk("R8 irq back", irq_sec, 1);
    // R9 write-one-to-clear
    wr(1, 8'h00); rd(1, v); chk("R9 zero write", v, 8'h02);
    wr(1, 8'h02); step();
    rd(1, v); chk("R9 cleared", v, 0);
    chk("R9 irq low", irq_sec, 0);
    @(negedge clk); bus_we = 1; bus_addr = 1; bus_wdata = 8'h02; sec_tick = 1;
    @(negedge clk); bus_we = 0; sec_tick = 0;
    rd(1, v); chk("R9 set wins", v, 8'h02);
    // R4 alarm with irq, then R10 read-modify-write of control
    wr(0, 8'h18); wr(2, 8'h30); wr(3, 8'h12);
    tick(8'h00, 8'h30, 8'h12, 4); step();
    chk("R4 irq_alarm", irq_alarm, 1);
    rd(1, v); chk("R4 status", v, 8'h03);
    rd(0, v); wr(0, v & ~8'h10); step();
    rd(1, v); chk("R10 pend kept", v, 8'h03);
    chk("R10 irq_alarm", irq_alarm, 0);
    chk("R10 irq_sec", irq_sec, 1);
    wr(1, 8'h03);
    // R4 / R6 sweep of all masks against all weekdays, second enable off
    wr(0, 8'h10);
    for (int d = 0; d < NDAYS; d++) begin
      for (int m = 0; m < 128; m++) begin
        wr(4, 8'(m));
        tick(8'h00, 8'h30, 8'h12, d);
        rd(1, v);
        chk("R6 mask day", int'(v), (m >> d) & 1);
        if (v != 0) wr(1, 8'h01);
      end
    end
    // R4 minute and hour sweeps
    wr(4, 8'h7F);
    for (int m = 0; m < 60; m++) begin
      tick(8'h00, bcd(m), 8'h12, 3);
      rd(1, v); chk("R4 minute", v, (m == 30) ? 1 : 0);
      if (v != 0) wr(1, 8'h01);
    end
    for (int h = 0; h < 24; h++) begin
      tick(8'h00, 8'h30, bcd(h), 5);
      rd(1, v); chk("R4 hour", v, (h == 12) ? 1 : 0);
      if (v != 0) wr(1, 8'h01);
    end
    // R5 non-zero seconds never fire
    for (int s = 1; s < 60; s++) begin
      tick(bcd(s), 8'h30, 8'h12, 0);
      rd(1, v); chk("R5 second", v, 0);
    end
    chk("R5 irq_alarm", irq_alarm, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule